// File: doc/BRIEF.md
# Packet Receive Queue with Register Read-Out

This block takes packets arriving on a 32-bit AXI4-Stream slave port and holds them until software drains them through a small register port. Every accepted beat goes into a word store. When the beat that carries TLAST is accepted, the packet's byte count is pushed into a separate length queue. This count is four times the number of beats, the TLAST beat included.

Software works through a fixed sequence. It polls a count of complete, unread words. It reads the length register, which takes the oldest packet length off the queue and opens that packet for reading. It then reads the data register once per word. Five single-cycle event pulses report the following conditions:

- a packet has finished arriving;
- the data register was read while the store was empty;
- a packet was left before all its words were read;
- the data register was read past the end of the open packet;
- a receive-side reset has completed.

An external interrupt bank is expected to latch these pulses.

Top module: `rx_stream_to_regs`

Register offsets (byte addresses on `regAddr`): 0x18 receive reset (write 0xA5), 0x1C occupancy (read), 0x20 data (read), 0x24 length (read), 0x28 full core reset (write 0xA5). Any other offset reads as zero.

## Requirements
- R1: Offset 0x1C reads the number of stored words that belong to packets whose TLAST beat has been accepted and that have not yet been read or discarded. Beats of a packet still missing its TLAST are not counted.
- R2: A read of offset 0x24 with a length queued returns that packet's byte count (4 × beats) and removes the entry. With no length queued, the read returns 0 and changes no state.
- R3: After a length read, each read of offset 0x20 returns the next word of that packet, in arrival order, and removes it.
- R4: `evtRecvDone` pulses for exactly one cycle, in the cycle after the TLAST beat is accepted.
- R5: A write of 0xA5 to offset 0x18 empties the word store and the length queue, drops any partly received packet, and closes the open packet. `evtResetDone` pulses in the next cycle. A write of any other value to offset 0x18 changes nothing.
- R6: A write of 0xA5 to offset 0x28 clears the same state as R5 but does not raise `evtResetDone`.
- R7: A read of offset 0x20 when the open packet has no words left, but the store still holds words, returns 0, removes nothing, and pulses `evtOverRead`.
- R8: A read of offset 0x20 when the store is empty returns 0 and pulses `evtUnderrun`.
- R9: A length read that succeeds while the open packet still has unread words pulses `evtUnderRead` and discards those words, so the data reads that follow return the new packet's words.
- R10: `sTready` is low whenever the word store holds `DATA_DEPTH` words or the length queue holds `LEN_DEPTH` entries, and high otherwise.
- R11: `regRdata` carries the result of a read in the cycle after `regRe` is sampled. The access-related events pulse in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sTdata | input | 32 | Stream data word |
| sTvalid | input | 1 | Stream beat valid |
| sTready | output | 1 | Block can accept a beat |
| sTlast | input | 1 | Last beat of packet |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after the read |
| evtRecvDone | output | 1 | Packet fully stored |
| evtUnderrun | output | 1 | Data read while the store is empty |
| evtUnderRead | output | 1 | Packet left with words unread |
| evtOverRead | output | 1 | Data read past the end of the packet |
| evtResetDone | output | 1 | Receive reset completed |

## Verification
Every register access and stream beat produces its result exactly one clock edge later:

- read data and the access events follow the edge that samples `regRe`;
- `evtRecvDone` follows the edge that accepts the TLAST beat;
- the clearing effects follow the edge that samples a reset write.

The bench drives each stimulus on a falling edge and samples at the next falling edge, which lands after that single edge. `sTready` depends only on registered counts, so it is sampled at a falling edge after the state change. The sweep covers packet lengths 1 to 8, with expected words and byte counts computed from the packet index.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [5:0]  OFS_RXRST = 6'h18;
  localparam logic [5:0]  OFS_OCC   = 6'h1C;
  localparam logic [5:0]  OFS_DATA  = 6'h20;
  localparam logic [5:0]  OFS_LEN   = 6'h24;
  localparam logic [5:0]  OFS_CORE  = 6'h28;
  localparam logic [31:0] RESET_KEY = 32'h0000_00A5;

  // strobes from control to datapath
  typedef struct packed {
    logic        popData;  // remove one word at the read pointer
    logic        popLen;   // remove the head length entry
    logic        clear;    // empty all storage
    logic [15:0] dropCnt;  // words to skip at once (under-read discard)
  } rxStrobeT;
endpackage

// File: rtl/rx_datapath.sv
module rx_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int LQ_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxStrobeT                   stb,
  input  logic [31:0]                sData,
  input  logic                       sValid,
  input  logic                       sLast,
  output logic                       sReady,
  output logic [31:0]                rdWord,
  output logic [$clog2(DEPTH)+2:0]   lenHead,
  output logic                       lenAvail,
  output logic [$clog2(DEPTH):0]     dataCount,
  output logic [$clog2(DEPTH):0]     committed,
  output logic                       pktDone
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int BW  = CW + 2;
  localparam int LAW = $clog2(LQ_DEPTH);
  localparam int LCW = LAW + 1;

  logic [31:0]    mem [DEPTH];
  logic [BW-1:0]  lq  [LQ_DEPTH];
  logic [AW-1:0]  wrPtr, rdPtr;
  logic [LAW-1:0] lqWr, lqRd;
  logic [LCW-1:0] lqCount;
  logic [CW-1:0]  inWords, pktWords, dropCw, popCw;
  logic           beat, lastBeat;

  assign sReady   = (dataCount != CW'(DEPTH)) && (lqCount != LCW'(LQ_DEPTH));
  assign beat     = sValid && sReady;
  assign lastBeat = beat && sLast;
  assign pktWords = inWords + 1'b1;
  assign dropCw   = CW'(stb.dropCnt);
  assign popCw    = CW'(stb.popData);
  assign rdWord   = mem[rdPtr];
  assign lenHead  = lq[lqRd];
  assign lenAvail = lqCount != '0;

  always_ff @(posedge clk) begin
    if (beat) mem[wrPtr] <= sData;
    if (lastBeat) lq[lqWr] <= {pktWords, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      lqWr      <= '0;
      lqRd      <= '0;
      lqCount   <= '0;
      inWords   <= '0;
      dataCount <= '0;
      committed <= '0;
      pktDone   <= 1'b0;
    end else begin
      if (beat) begin
        wrPtr   <= wrPtr + 1'b1;
        inWords <= sLast ? '0 : pktWords;
      end
      if (lastBeat)   lqWr <= lqWr + 1'b1;
      if (stb.popLen) lqRd <= lqRd + 1'b1;
      lqCount   <= lqCount + LCW'(lastBeat) - LCW'(stb.popLen);
      rdPtr     <= rdPtr + AW'(stb.popData) + AW'(stb.dropCnt);
      dataCount <= dataCount + CW'(beat) - popCw - dropCw;
      committed <= committed + (lastBeat ? pktWords : '0) - popCw - dropCw;
      pktDone   <= lastBeat;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    dataCount <= CW'(DEPTH) && lqCount <= LCW'(LQ_DEPTH)); // R10
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    stb.popData |-> dataCount != '0); // R3
  AST_LEN_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.popLen |-> lqCount != '0); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> dataCount == '0 && lqCount == '0 && committed == '0); // R5
  AST_OCC_WITH_PKT: assert property (@(posedge clk) disable iff (!rstN)
    lqCount != '0 |-> committed != '0); // R1
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [5:0]                 regAddr,
  input  logic [31:0]                regWdata,
  input  logic [31:0]                rdWord,
  input  logic [$clog2(DEPTH)+2:0]   lenHead,
  input  logic                       lenAvail,
  input  logic [$clog2(DEPTH):0]     dataCount,
  input  logic [$clog2(DEPTH):0]     committed,
  output rxStrobeT                   stb,
  output logic [31:0]                regRdata,
  output logic                       evtUnderrun,
  output logic                       evtOverRead,
  output logic                       evtUnderRead,
  output logic                       evtResetDone
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] curRemain;
  logic          isData, isLen, wrRx, wrCore;
  logic [31:0]   nextRd;

  assign isData = regRe && regAddr == OFS_DATA;
  assign isLen  = regRe && regAddr == OFS_LEN;
  assign wrRx   = regWe && regAddr == OFS_RXRST && regWdata == RESET_KEY;
  assign wrCore = regWe && regAddr == OFS_CORE  && regWdata == RESET_KEY;

  always_comb begin
    stb         = '0;
    stb.clear   = wrRx || wrCore;
    stb.popData = isData && curRemain != '0 && !stb.clear;
    if (isLen && lenAvail && !stb.clear) begin
      stb.popLen  = 1'b1;
      stb.dropCnt = 16'(curRemain);
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_OCC:  nextRd = 32'(committed);
      OFS_DATA: nextRd = (curRemain != '0) ? rdWord : '0;
      OFS_LEN:  nextRd = lenAvail ? 32'(lenHead) : '0;
      default:  nextRd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRemain    <= '0;
      regRdata     <= '0;
      evtUnderrun  <= 1'b0;
      evtOverRead  <= 1'b0;
      evtUnderRead <= 1'b0;
      evtResetDone <= 1'b0;
    end else begin
      if (regRe) regRdata <= nextRd;
      if (stb.clear)        curRemain <= '0;
      else if (stb.popLen)  curRemain <= CW'(lenHead >> 2);
      else if (stb.popData) curRemain <= curRemain - 1'b1;
      evtUnderRead <= stb.popLen && curRemain != '0;
      evtOverRead  <= isData && curRemain == '0 && dataCount != '0;
      evtUnderrun  <= isData && curRemain == '0 && dataCount == '0;
      evtResetDone <= wrRx;
    end
  end

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtUnderrun, evtOverRead, evtUnderRead})); // R7
  AST_REMAIN_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    curRemain <= committed); // R3
endmodule

// File: rtl/rx_stream_to_regs.sv
module rx_stream_to_regs
  import rxq_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int LEN_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] sTdata,
  input  logic        sTvalid,
  output logic        sTready,
  input  logic        sTlast,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [5:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        evtRecvDone,
  output logic        evtUnderrun,
  output logic        evtUnderRead,
  output logic        evtOverRead,
  output logic        evtResetDone
);
  localparam int CW = $clog2(DATA_DEPTH) + 1;

  rxStrobeT        stb;
  logic [31:0]     rdWord;
  logic [CW+1:0]   lenHead;
  logic            lenAvail;
  logic [CW-1:0]   dataCount, committed;

  rx_datapath #(.DEPTH(DATA_DEPTH), .LQ_DEPTH(LEN_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sData(sTdata), .sValid(sTvalid), .sLast(sTlast), .sReady(sTready),
    .rdWord(rdWord), .lenHead(lenHead), .lenAvail(lenAvail),
    .dataCount(dataCount), .committed(committed), .pktDone(evtRecvDone)
  );

  rx_ctrl #(.DEPTH(DATA_DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata),
    .rdWord(rdWord), .lenHead(lenHead), .lenAvail(lenAvail),
    .dataCount(dataCount), .committed(committed), .stb(stb),
    .regRdata(regRdata), .evtUnderrun(evtUnderrun), .evtOverRead(evtOverRead),
    .evtUnderRead(evtUnderRead), .evtResetDone(evtResetDone)
  );
endmodule

// File: tb/sim_rx_stream_to_regs.sv
module sim_rx_stream_to_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sTdata = '0;
  logic        sTvalid = 1'b0, sTlast = 1'b0, sTready;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        evtRecvDone, evtUnderrun, evtUnderRead, evtOverRead, evtResetDone;
  int          errors = 0, checks = 0;
  logic [31:0] d;

  always #2 clk = ~clk; // 250 MHz

  rx_stream_to_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); regAddr = a; regRe = 1'b1;
    @(negedge clk); regRe = 1'b0; v = regRdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); regAddr = a; regWdata = v; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic beat(input logic [31:0] v, input logic last);
    @(negedge clk); sTdata = v; sTlast = last; sTvalid = 1'b1;
    while (!sTready) @(negedge clk);
    @(negedge clk); sTvalid = 1'b0; sTlast = 1'b0;
    if (last) chk("R4 recvDone after TLAST", 32'(evtRecvDone), 32'd1);
  endtask

  task automatic sendPkt(input int n, input int base);
    for (int i = 0; i < n; i++) beat(32'(base + i), i == n - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R10 reset tready", 32'(sTready), 32'd1);
    rd(6'h1C, d); chk("R1 reset occupancy", d, 0);
    rd(6'h24, d); chk("R2 empty length", d, 0);

    // sweep packet lengths
    for (int len = 1; len <= 8; len++) begin
      sendPkt(len, len * 256);
      rd(6'h1C, d); chk("R1 occupancy", d, 32'(len));
      rd(6'h24, d); chk("R2 length bytes", d, 32'(4 * len));
      for (int i = 0; i < len; i++) begin
        rd(6'h20, d); chk("R3 data word", d, 32'(len * 256 + i));
      end
      rd(6'h1C, d); chk("R1 drained occupancy", d, 0);
    end
    rd(6'h20, d);
    chk("R8 underrun flag", 32'(evtUnderrun), 1);
    chk("R8 underrun data", d, 0);

    // over-read with next packet stored
    sendPkt(3, 32'h300); sendPkt(2, 32'h400);
    rd(6'h24, d); chk("R2 first length", d, 12);
    for (int i = 0; i < 3; i++) begin rd(6'h20, d); chk("R3 word", d, 32'(32'h300 + i)); end
    rd(6'h20, d);
    chk("R7 overread flag", 32'(evtOverRead), 1);
    chk("R7 overread data", d, 0);
    rd(6'h1C, d); chk("R7 nothing removed", d, 2);
    rd(6'h24, d); chk("R2 second length", d, 8);
    chk("R9 no underread on clean move", 32'(evtUnderRead), 0);
    for (int i = 0; i < 2; i++) begin rd(6'h20, d); chk("R3 word", d, 32'(32'h400 + i)); end

    // under-read discards rest
    sendPkt(4, 32'h100); sendPkt(2, 32'h200);
    rd(6'h24, d); chk("R2 length", d, 16);
    rd(6'h20, d); chk("R3 first word", d, 32'h100);
    rd(6'h24, d);
    chk("R9 underread flag", 32'(evtUnderRead), 1);
    chk("R9 next length", d, 8);
    rd(6'h1C, d); chk("R9 occupancy after discard", d, 2);
    for (int i = 0; i < 2; i++) begin rd(6'h20, d); chk("R9 next packet word", d, 32'(32'h200 + i)); end

    // partial packet
    beat(32'h500, 1'b0); beat(32'h501, 1'b0);
    rd(6'h1C, d); chk("R1 partial not counted", d, 0);
    rd(6'h24, d); chk("R2 no complete packet", d, 0);
    rd(6'h20, d); chk("R7 overread on partial", 32'(evtOverRead), 1);
    beat(32'h502, 1'b1);
    rd(6'h1C, d); chk("R1 completed packet", d, 3);

    // receive reset
    wr(6'h18, 32'h5A);
    rd(6'h1C, d); chk("R5 wrong key ignored", d, 3);
    @(negedge clk); regAddr = 6'h18; regWdata = 32'hA5; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
    chk("R5 resetDone", 32'(evtResetDone), 1);
    rd(6'h1C, d); chk("R5 occupancy cleared", d, 0);
    rd(6'h24, d); chk("R5 lengths cleared", d, 0);

    // length queue full
    for (int p = 0; p < 4; p++) sendPkt(1, 32'h600 + p);
    chk("R10 len queue full", 32'(sTready), 0);
    rd(6'h24, d); chk("R2 length", d, 4);
    chk("R10 ready after pop", 32'(sTready), 1);
    wr(6'h28, 32'hA5);

    // word store full
    for (int i = 0; i < 16; i++) beat(32'(32'h700 + i), 1'b0);
    chk("R10 store full", 32'(sTready), 0);
    @(negedge clk); regAddr = 6'h28; regWdata = 32'hA5; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
    chk("R6 no resetDone", 32'(evtResetDone), 0);
    chk("R6 ready after core reset", 32'(sTready), 1);
    rd(6'h1C, d); chk("R6 occupancy cleared", d, 0);
    rd(6'h20, d); chk("R11 R8 underrun after core reset", 32'(evtUnderrun), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule